// File: doc/BRIEF.md
# Network Controller Command and Status Register Block

This block is the register interface between driver software and a network controller that has a separate receive engine and transmit engine. Software reads one 32-bit word that carries a 16-bit status half and a 16-bit command half. The status half shows latched events and the current state code of each engine. The command half takes a command for each engine, holds the interrupt mask, and has a trigger that raises a software event. A second word holds a 32-bit operand pointer, which the engines use for start and load commands.

Event bits are set by single-cycle pulses from the engines and cleared when software writes 1s to them. A command code stays in its field until the engine that owns it pulses its accept input. The field then reads back as zero, and software polls for that zero before it issues the next command. The interrupt output is high while any latched event exists and the mask is clear. The engines are outside this block. It only shows them the pending codes and the pointer, and it takes their accept pulses, state codes and event pulses.

Top module: `cs_regblk`

## Requirements
- R1: After reset all event bits, both command fields and the pointer are zero, the mask bit (command bit 8, bus bit 24) is 1, `irq` is low and neither pending flag is set.
- R2: A pulse on an event input sets its status bit at the next clock edge. The mapping is: transmit command done bit 15, frame received bit 14, transmit unit left active bit 13, receive unit left ready bit 12, management cycle done bit 11, flow-control pause bit 8. Status bit 9 always reads 0.
- R3: A write to offset 0 with byte enable 1 clears every event bit (15:10, 8) whose data bit is 1 and leaves the others unchanged. If an event is set and cleared in the same cycle, the bit stays set. A write without byte enable 1 clears nothing.
- R4: A write to offset 0 with byte enable 3 and bus bit 25 (command bit 9) set raises the software event in status bit 10. Command bit 9 always reads 0.
- R5: `irq` is high exactly when at least one event bit is set and the mask bit is 0. A write with byte enable 3 loads the mask from bus bit 24.
- R6: A write with byte enable 2 loads the transmit code from bus bits 23:20 (command bits 7:4) when the code is one of 0,1,2,4,5,6,7. It loads the receive code from bus bits 18:16 (command bits 2:0) when the code is one of 0,1,2,4,6,7. The two fields are checked separately, and a field ignores a code outside its set. Command bit 3 reads 0. `txCmd`/`rxCmd` present the fields, and each pending flag is high while its field is nonzero.
- R7: `txAccept` clears only the transmit field and `rxAccept` clears only the receive field, one clock edge later. A legal code written in the same cycle as the accept stays in the field.
- R8: A legal code written while an earlier code is still pending replaces it.
- R9: Offset 4 holds the pointer, written byte by byte under the byte enables, read back there and driven on `cmdPtr`. Any other offset reads zero and ignores writes.
- R10: Status bits 5:2 present the receive state code: idle 0, suspended 1, no resources 2, ready 4. When `rxNoBufDesc` is high and the state is not idle, 8 is added. `rxState` encodes idle 0, suspended 1, no resources 2, ready 3.
- R11: Status bits 7:6 present `txState`, status bits 1:0 read 0, and writes to status bits 7:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Byte address of the write, word aligned |
| wrData | input | 32 | Write data |
| wrBe | input | 4 | Byte enables of the write |
| rdAddr | input | ADDR_W | Byte address of the read |
| rdData | output | 32 | Read data, combinational from rdAddr |
| txDoneEv | input | 1 | Event pulse: transmit command done |
| rxFrameEv | input | 1 | Event pulse: frame received |
| txLeftActiveEv | input | 1 | Event pulse: transmit unit left active |
| rxLeftReadyEv | input | 1 | Event pulse: receive unit left ready |
| mgmtDoneEv | input | 1 | Event pulse: management cycle done |
| pauseEv | input | 1 | Event pulse: flow-control pause |
| txState | input | 2 | Transmit unit state code |
| rxState | input | 2 | Receive unit base state |
| rxNoBufDesc | input | 1 | Receive unit has no buffer descriptors |
| txCmd | output | 4 | Pending transmit command code |
| txCmdPending | output | 1 | Transmit field is nonzero |
| txAccept | input | 1 | Transmit engine takes its command |
| rxCmd | output | 3 | Pending receive command code |
| rxCmdPending | output | 1 | Receive field is nonzero |
| rxAccept | input | 1 | Receive engine takes its command |
| cmdPtr | output | PTR_W | Operand pointer for the engines |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that an engine pulses its accept only while its own field is nonzero, because a real engine has nothing to accept otherwise. That assumption is itself checked as a property. The random stimulus drives each accept only when the bench's own model shows that field pending, so accepts often land in the same cycle as a new write. The event inputs, write data, byte enables, offsets and state inputs are random and unconstrained. Illegal command codes and simultaneous set-and-acknowledge of the same bit therefore occur often, and no timing assumption is placed on them.

// File: rtl/cs_regblk_pkg.sv
package cs_regblk_pkg;

  localparam int BUS_W = 32;
  localparam int BE_W = BUS_W / 8;
  localparam int HALF_W = 16;

  // offsets of the two mapped words
  localparam int STAT_OFS = 0;
  localparam int PTR_OFS = 4;

  // event bit positions inside the status half
  localparam int EV_TXDONE = 15;
  localparam int EV_RXFRAME = 14;
  localparam int EV_TXLEFT = 13;
  localparam int EV_RXLEFT = 12;
  localparam int EV_MGMT = 11;
  localparam int EV_SWI = 10;
  localparam int EV_PAUSE = 8;
  localparam logic [HALF_W-1:0] EV_MASK = 16'hFD00;

  // command half layout
  localparam int TXF_LSB = 4;
  localparam int TXF_W = 4;
  localparam int RXF_LSB = 0;
  localparam int RXF_W = 3;
  localparam int MASK_BIT = 8;
  localparam int SWI_BIT = 9;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SUSP  = 2'd1,
    RX_NORES = 2'd2,
    RX_READY = 2'd3
  } rxUnitE;

  // strobes from the write decoder to the register datapath
  typedef struct packed {
    logic [HALF_W-1:0] ackBits;
    logic              txLoad;
    logic [TXF_W-1:0]  txCode;
    logic              rxLoad;
    logic [RXF_W-1:0]  rxCode;
    logic              maskLoad;
    logic              maskVal;
    logic              swiSet;
    logic [BE_W-1:0]   ptrBe;
  } wrStrobeT;

  function automatic logic txCodeOk(input logic [TXF_W-1:0] code);
    return (code < 4'd8) && (code != 4'd3);
  endfunction

  function automatic logic rxCodeOk(input logic [RXF_W-1:0] code);
    return (code != 3'd3) && (code != 3'd5);
  endfunction

  function automatic logic [3:0] rxStateCode(input rxUnitE st, input logic noBd);
    logic [3:0] code;
    case (st)
      RX_IDLE:  code = 4'd0;
      RX_SUSP:  code = 4'd1;
      RX_NORES: code = 4'd2;
      default:  code = 4'd4;
    endcase
    if (noBd && (st != RX_IDLE)) code[3] = 1'b1;
    return code;
  endfunction

endpackage

// File: rtl/cs_regblk_ctrl.sv
module cs_regblk_ctrl
  import cs_regblk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PTR_W = 32
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [BE_W-1:0]   wrBe,
  output wrStrobeT          strobe,
  output logic [PTR_W-1:0]  ptrData
);

  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] PTR_A = ADDR_W'(PTR_OFS);

  logic hitStat;
  logic hitPtr;
  logic [TXF_W-1:0] txCodeW;
  logic [RXF_W-1:0] rxCodeW;
  logic unusedBits;

  assign hitStat = wrEn && (wrAddr == STAT_A);
  assign hitPtr = wrEn && (wrAddr == PTR_A);
  assign txCodeW = wrData[HALF_W+TXF_LSB +: TXF_W];
  assign rxCodeW = wrData[HALF_W+RXF_LSB +: RXF_W];
  assign ptrData = wrData[PTR_W-1:0];
  assign unusedBits = ^{wrData[7:0], wrData[HALF_W+3], wrData[BUS_W-1:HALF_W+SWI_BIT+1], wrBe[0]};

  always_comb begin
    strobe = '0;
    strobe.txCode = txCodeW;
    strobe.rxCode = rxCodeW;
    strobe.maskVal = wrData[HALF_W+MASK_BIT];
    if (hitStat) begin
      if (wrBe[1]) strobe.ackBits = {wrData[15:8], 8'h00} & EV_MASK;
      if (wrBe[2]) begin
        strobe.txLoad = txCodeOk(txCodeW);
        strobe.rxLoad = rxCodeOk(rxCodeW);
      end
      if (wrBe[3]) begin
        strobe.maskLoad = 1'b1;
        strobe.swiSet = wrData[HALF_W+SWI_BIT];
      end
    end
    if (hitPtr) strobe.ptrBe = wrBe;
  end

endmodule

// File: rtl/cs_regblk_dp.sv
module cs_regblk_dp
  import cs_regblk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobeT          strobe,
  input  logic [PTR_W-1:0]  ptrWrData,
  input  logic [HALF_W-1:0] evSet,
  input  logic              txAccept,
  input  logic              rxAccept,
  input  logic [1:0]        txState,
  input  logic [1:0]        rxState,
  input  logic              rxNoBufDesc,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [BUS_W-1:0]  rdData,
  output logic [TXF_W-1:0]  txCmd,
  output logic              txCmdPending,
  output logic [RXF_W-1:0]  rxCmd,
  output logic              rxCmdPending,
  output logic [PTR_W-1:0]  cmdPtr,
  output logic              irq
);

  localparam int PTR_BYTES = PTR_W / 8;
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] PTR_A = ADDR_W'(PTR_OFS);

  logic [HALF_W-1:0] newSet;
  logic [HALF_W-1:0] evReg;
  logic [TXF_W-1:0]  txField;
  logic [RXF_W-1:0]  rxField;
  logic              maskQ;
  logic [PTR_W-1:0]  ptrQ;
  logic [3:0]        rxCodeOut;
  logic [HALF_W-1:0] statusWord;
  logic [HALF_W-1:0] cmdWord;

  assign newSet = (evSet | (strobe.swiSet ? (HALF_W'(1) << EV_SWI) : '0)) & EV_MASK;

  // one latch per implemented event bit, constant zero elsewhere
  for (genvar gi = 0; gi < HALF_W; gi++) begin : g_ev
    if (EV_MASK[gi]) begin : g_live
      logic bitQ;
      always_ff @(posedge clk) begin
        if (!rstN) bitQ <= 1'b0;
        else if (newSet[gi]) bitQ <= 1'b1;
        else if (strobe.ackBits[gi]) bitQ <= 1'b0;
      end
      assign evReg[gi] = bitQ;
    end else begin : g_tie
      assign evReg[gi] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txField <= '0;
    else if (strobe.txLoad) txField <= strobe.txCode;
    else if (txAccept) txField <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxField <= '0;
    else if (strobe.rxLoad) rxField <= strobe.rxCode;
    else if (rxAccept) rxField <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= 1'b1;
    else if (strobe.maskLoad) maskQ <= strobe.maskVal;
  end

  for (genvar gb = 0; gb < PTR_BYTES; gb++) begin : g_ptr
    logic [7:0] byteQ;
    always_ff @(posedge clk) begin
      if (!rstN) byteQ <= '0;
      else if (strobe.ptrBe[gb]) byteQ <= ptrWrData[8*gb +: 8];
    end
    assign ptrQ[8*gb +: 8] = byteQ;
  end

  assign rxCodeOut = rxStateCode(rxUnitE'(rxState), rxNoBufDesc);
  assign statusWord = evReg | {8'h00, txState, rxCodeOut, 2'b00};
  assign cmdWord = {7'b0, maskQ, txField, 1'b0, rxField};

  always_comb begin
    rdData = '0;
    if (rdAddr == STAT_A) rdData = {cmdWord, statusWord};
    else if (rdAddr == PTR_A) rdData = BUS_W'(ptrQ);
  end

  assign txCmd = txField;
  assign rxCmd = rxField;
  assign txCmdPending = |txField;
  assign rxCmdPending = |rxField;
  assign cmdPtr = ptrQ;
  assign irq = (|evReg) & ~maskQ;

  // R2
  ev_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|newSet) |=> ((evReg & $past(newSet)) == $past(newSet)));

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobe.ackBits & ~newSet)) |=> ((evReg & $past(strobe.ackBits & ~newSet)) == '0));

  // R5
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|newSet) && !maskQ && !strobe.maskLoad) |=> irq);

  // R6
  tx_code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    txCodeOk(txField));

  // R6
  rx_code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxCodeOk(rxField));

  // R7
  tx_accept_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txAccept && !strobe.txLoad) |=> (txCmd == '0));

  // R7
  rx_accept_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxAccept && !strobe.rxLoad) |=> (rxCmd == '0));

  // R7
  accept_when_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txAccept |-> txCmdPending) and (rxAccept |-> rxCmdPending));

endmodule

// File: rtl/cs_regblk.sv
module cs_regblk
  import cs_regblk_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PTR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [3:0]        wrBe,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  input  logic              txDoneEv,
  input  logic              rxFrameEv,
  input  logic              txLeftActiveEv,
  input  logic              rxLeftReadyEv,
  input  logic              mgmtDoneEv,
  input  logic              pauseEv,
  input  logic [1:0]        txState,
  input  logic [1:0]        rxState,
  input  logic              rxNoBufDesc,
  output logic [3:0]        txCmd,
  output logic              txCmdPending,
  input  logic              txAccept,
  output logic [2:0]        rxCmd,
  output logic              rxCmdPending,
  input  logic              rxAccept,
  output logic [PTR_W-1:0]  cmdPtr,
  output logic              irq
);

  wrStrobeT strobe;
  logic [PTR_W-1:0] ptrData;
  logic [HALF_W-1:0] evSet;

  always_comb begin
    evSet = '0;
    evSet[EV_TXDONE] = txDoneEv;
    evSet[EV_RXFRAME] = rxFrameEv;
    evSet[EV_TXLEFT] = txLeftActiveEv;
    evSet[EV_RXLEFT] = rxLeftReadyEv;
    evSet[EV_MGMT] = mgmtDoneEv;
    evSet[EV_PAUSE] = pauseEv;
  end

  cs_regblk_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
    .wrEn(wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .wrBe(wrBe),
    .strobe(strobe),
    .ptrData(ptrData)
  );

  cs_regblk_dp #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .ptrWrData(ptrData),
    .evSet(evSet),
    .txAccept(txAccept),
    .rxAccept(rxAccept),
    .txState(txState),
    .rxState(rxState),
    .rxNoBufDesc(rxNoBufDesc),
    .rdAddr(rdAddr),
    .rdData(rdData),
    .txCmd(txCmd),
    .txCmdPending(txCmdPending),
    .rxCmd(rxCmd),
    .rxCmdPending(rxCmdPending),
    .cmdPtr(cmdPtr),
    .irq(irq)
  );

endmodule

// File: tb/test_cs_regblk.sv
`timescale 1ns/100ps
module test_cs_regblk;

  logic clk = 1'b0;
  logic rstN;
  logic wrEn;
  logic [3:0] wrAddr;
  logic [31:0] wrData;
  logic [3:0] wrBe;
  logic [3:0] rdAddr;
  logic [31:0] rdData;
  logic txDoneEv, rxFrameEv, txLeftActiveEv, rxLeftReadyEv, mgmtDoneEv, pauseEv;
  logic [1:0] txState;
  logic [1:0] rxState;
  logic rxNoBufDesc;
  logic [3:0] txCmd;
  logic txCmdPending;
  logic txAccept;
  logic [2:0] rxCmd;
  logic rxCmdPending;
  logic rxAccept;
  logic [31:0] cmdPtr;
  logic irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // bench model
  logic [15:0] mEv;
  logic [3:0] mTx;
  logic [2:0] mRx;
  logic mMask;
  logic [31:0] mPtr;

  always #2 clk = ~clk;

  cs_regblk i_cs_regblk (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .rdAddr(rdAddr), .rdData(rdData),
    .txDoneEv(txDoneEv), .rxFrameEv(rxFrameEv), .txLeftActiveEv(txLeftActiveEv),
    .rxLeftReadyEv(rxLeftReadyEv), .mgmtDoneEv(mgmtDoneEv), .pauseEv(pauseEv),
    .txState(txState), .rxState(rxState), .rxNoBufDesc(rxNoBufDesc),
    .txCmd(txCmd), .txCmdPending(txCmdPending), .txAccept(txAccept),
    .rxCmd(rxCmd), .rxCmdPending(rxCmdPending), .rxAccept(rxAccept),
    .cmdPtr(cmdPtr), .irq(irq)
  );

  function automatic logic txLegal(input logic [3:0] c);
    return c inside {4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7};
  endfunction

  function automatic logic rxLegal(input logic [2:0] c);
    return c inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd6, 3'd7};
  endfunction

  // R10 code table
  function automatic logic [3:0] rxExp(input logic [1:0] s, input logic nb);
    case ({s, nb})
      3'b000: return 4'd0;
      3'b001: return 4'd0;
      3'b010: return 4'd1;
      3'b011: return 4'd9;
      3'b100: return 4'd2;
      3'b101: return 4'd10;
      3'b110: return 4'd4;
      default: return 4'd12;
    endcase
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] a);
    logic [15:0] st;
    logic [15:0] cm;
    st = mEv | {8'h00, txState, rxExp(rxState, rxNoBufDesc), 2'b00};
    cm = {7'b0, mMask, mTx, 1'b0, mRx};
    if (a == 4'd0) return {cm, st};
    if (a == 4'd4) return mPtr;
    return 32'h0;
  endfunction

  task automatic modelReset();
    mEv = '0; mTx = '0; mRx = '0; mMask = 1'b1; mPtr = '0;
  endtask

  task automatic modelStep();
    logic wr0;
    logic [15:0] setV;
    logic [15:0] clrV;
    wr0 = wrEn && (wrAddr == 4'd0);
    setV = {txDoneEv, rxFrameEv, txLeftActiveEv, rxLeftReadyEv, mgmtDoneEv,
            wr0 && wrBe[3] && wrData[25], 1'b0, pauseEv, 8'h00};
    clrV = (wr0 && wrBe[1]) ? {wrData[15:8], 8'h00} : 16'h0;
    mEv = ((mEv & ~clrV) | setV) & 16'hFD00;
    if (txAccept) mTx = '0;
    if (rxAccept) mRx = '0;
    if (wr0 && wrBe[2] && txLegal(wrData[23:20])) mTx = wrData[23:20];
    if (wr0 && wrBe[2] && rxLegal(wrData[18:16])) mRx = wrData[18:16];
    if (wr0 && wrBe[3]) mMask = wrData[24];
    if (wrEn && (wrAddr == 4'd4))
      for (int b = 0; b < 4; b++) if (wrBe[b]) mPtr[8*b +: 8] = wrData[8*b +: 8];
  endtask

  task automatic idleInputs();
    wrEn = 0; wrAddr = 0; wrData = 0; wrBe = 0;
    txDoneEv = 0; rxFrameEv = 0; txLeftActiveEv = 0; rxLeftReadyEv = 0;
    mgmtDoneEv = 0; pauseEv = 0; txAccept = 0; rxAccept = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    rdAddr = 4'd0; #0.2;
    chk(rdData, expRead(4'd0), {tag, " word@0"});
    rdAddr = 4'd4; #0.2;
    chk(rdData, expRead(4'd4), {tag, " word@4"});
    rdAddr = 4'd8; #0.2;
    chk(rdData, expRead(4'd8), {tag, " word@8"});
    chk(32'(irq), 32'((|mEv) && !mMask), {tag, " irq"});
    chk(32'(txCmd), 32'(mTx), {tag, " txCmd"});
    chk(32'(txCmdPending), 32'(mTx != 0), {tag, " txCmdPending"});
    chk(32'(rxCmd), 32'(mRx), {tag, " rxCmd"});
    chk(32'(rxCmdPending), 32'(mRx != 0), {tag, " rxCmdPending"});
    chk(cmdPtr, mPtr, {tag, " cmdPtr"});
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    wrEn = 1; wrAddr = a; wrData = d; wrBe = be;
    tick();
    idleInputs();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL R1 watchdog: actual hung run, expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    idleInputs();
    rdAddr = 0; txState = 0; rxState = 0; rxNoBufDesc = 0;
    rstN = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1: reset values
    compareAll("R1");

    // R2: each event input sets its own bit
    for (int i = 0; i < 6; i++) begin
      case (i)
        0: txDoneEv = 1;
        1: rxFrameEv = 1;
        2: txLeftActiveEv = 1;
        3: rxLeftReadyEv = 1;
        4: mgmtDoneEv = 1;
        default: pauseEv = 1;
      endcase
      tick();
      idleInputs();
      compareAll("R2");
    end

    // R5: masked after reset, then unmask
    chk(32'(irq), 32'd0, "R5 masked irq");
    busWrite(4'd0, 32'h0000_0000, 4'b1000);
    compareAll("R5 unmasked");

    // R3: partial acknowledge, then set wins over clear, then clear all
    busWrite(4'd0, 32'h0000_A000, 4'b0010);
    compareAll("R3 partial ack");
    busWrite(4'd0, 32'h0000_FF00, 4'b0001);
    compareAll("R3 no byte enable");
    txDoneEv = 1;
    busWrite(4'd0, 32'h0000_8000, 4'b0010);
    compareAll("R3 set wins");
    busWrite(4'd0, 32'h0000_FF00, 4'b0010);
    compareAll("R3 ack all");

    // R4: software event
    busWrite(4'd0, 32'h0200_0000, 4'b1000);
    compareAll("R4 swi");

    // R6: legal codes load, illegal ones ignored
    busWrite(4'd0, 32'h0016_0000, 4'b0100);
    compareAll("R6 load");
    busWrite(4'd0, 32'h0035_0000, 4'b0100);
    compareAll("R6 illegal");
    busWrite(4'd0, 32'h0093_0000, 4'b0100);
    compareAll("R6 illegal high");

    // R8: overwrite pending code
    busWrite(4'd0, 32'h0057_0000, 4'b0100);
    compareAll("R8 overwrite");

    // R7: accept clears own field only, write wins on same cycle
    txAccept = 1;
    tick();
    idleInputs();
    compareAll("R7 tx accept");
    rxAccept = 1;
    busWrite(4'd0, 32'h0002_0000, 4'b0100);
    compareAll("R7 write wins");
    rxAccept = 1;
    tick();
    idleInputs();
    compareAll("R7 rx accept");

    // R9: pointer bytes and unmapped offset
    busWrite(4'd4, 32'hDEAD_BEEF, 4'b1111);
    busWrite(4'd4, 32'h1122_3344, 4'b0101);
    compareAll("R9 pointer");
    busWrite(4'd8, 32'hFFFF_FFFF, 4'b1111);
    compareAll("R9 unmapped");

    // R10: receive state codes
    for (int s = 0; s < 4; s++) begin
      for (int nb = 0; nb < 2; nb++) begin
        rxState = 2'(s); rxNoBufDesc = nb[0];
        #0.2;
        compareAll("R10");
      end
    end

    // R11: transmit state and read-only low byte
    for (int s = 0; s < 4; s++) begin
      txState = 2'(s);
      #0.2;
      compareAll("R11");
    end
    busWrite(4'd0, 32'h0000_00FF, 4'b0001);
    compareAll("R11 ro byte");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      wrEn = ($urandom % 3) == 0;
      case ($urandom % 3)
        0: wrAddr = 4'd0;
        1: wrAddr = 4'd4;
        default: wrAddr = 4'd8;
      endcase
      wrData = $urandom;
      wrBe = 4'($urandom);
      txDoneEv = ($urandom % 8) == 0;
      rxFrameEv = ($urandom % 8) == 0;
      txLeftActiveEv = ($urandom % 8) == 0;
      rxLeftReadyEv = ($urandom % 8) == 0;
      mgmtDoneEv = ($urandom % 8) == 0;
      pauseEv = ($urandom % 8) == 0;
      txAccept = (mTx != 0) && (($urandom % 4) == 0);
      rxAccept = (mRx != 0) && (($urandom % 4) == 0);
      txState = 2'($urandom);
      rxState = 2'($urandom);
      rxNoBufDesc = 1'($urandom);
      tick();
      idleInputs();
      compareAll("random R3 R5 R6 R7 R8");
    end

    finishRun();
  end

endmodule